// File: doc/BRIEF.md
# Coprocessor Memory Channel Controller

This block moves words between one coprocessor stream port and system memory on behalf of software. Software fills a small register bank with a mode, a word-addressed buffer base and a buffer length. It then writes a non-zero value to the run register. The channel's direction is fixed by a parameter. A to-coprocessor channel reads memory and offers each word on a valid/ready output. A from-coprocessor channel accepts words on a valid/ready input and writes each one to memory.

There are three ways to run a channel. In stream mode the buffer is a circular region that is walked endlessly, and completion is never reported. In the two single-buffer modes exactly one buffer is moved. The channel then parks with its done flag set until software writes zero to run. One of these modes signals completion on the interrupt line. The other leaves completion to be found by polling the status register. An error response from memory stops the channel in every mode, sets the error flag and raises the interrupt.

Top module: `copro_mem_channel`

## Requirements
- R1: After reset the interrupt is low, the status register reads 0, and no memory request, output word or input acceptance is offered.
- R2: Register offsets on cfg_sel are 0 mode (2 bits, upper bits dropped), 1 buffer base (word address), 2 buffer length in words (LEN_W bits), 3 run, 4 status (bit0 done, bit1 error). Unused offsets read 0. Writes to status are ignored.
- R3: Mode codes are 0 stream, 1 single buffer with interrupt, 2 single buffer polled, 3 behaves as 2. Any non-zero run value starts an idle channel, and its first request goes to the base address.
- R4: A to-coprocessor channel issues reads and presents each good read word on the output in order, holding it until accepted. A from-coprocessor channel writes each accepted input word, in order, to the next address.
- R5: At most one memory request is outstanding. A request is held stable until accepted, and no new request is issued before the response arrives.
- R6: In stream mode the address runs base, base+1, … base+length-1 and then wraps to base, and the done flag is never set.
- R7: In the single-buffer modes exactly length requests are issued. Done is then set, and it stays set with no further requests while run remains non-zero.
- R8: On completion, mode 1 raises the interrupt, and mode 2 leaves the interrupt low with done readable in status.
- R9: A memory error response in any mode sets status bit1, raises the interrupt and stops further requests.
- R10: Writing zero to run returns the channel to idle and clears done, error and the interrupt. A running stream stops at the next word boundary.
- R11: Starting a single-buffer mode with length 0 sets done without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register offset |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational on cfg_sel) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_rdata | input | DATA_W | Read data |
| cop_out_valid | output | 1 | Word to coprocessor valid |
| cop_out_ready | input | 1 | Coprocessor accepts word |
| cop_out_data | output | DATA_W | Word to coprocessor |
| cop_in_valid | input | 1 | Word from coprocessor valid |
| cop_in_ready | output | 1 | Channel accepts word |
| cop_in_data | input | DATA_W | Word from coprocessor |
| irq | output | 1 | Interrupt (level) |

## Verification
The transfer path is run with a ready memory and output, and again with back-pressure on both request acceptance and output. These two runs separate hold-until-accepted behaviour from plain sequencing. A stream run longer than the buffer shows wrap-around and the absence of done, which tells stream mode apart from the single-buffer modes. The interrupt-raising and polled buffer runs differ only in the interrupt line. Errors injected mid-buffer and mid-stream, a zero-length buffer and a from-coprocessor write channel cover the stop, park and direction paths.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_LEN_W  = 16;
    localparam int SEL_W      = 3;

    localparam logic [SEL_W-1:0] OFS_MODE   = 3'd0;
    localparam logic [SEL_W-1:0] OFS_BASE   = 3'd1;
    localparam logic [SEL_W-1:0] OFS_LEN    = 3'd2;
    localparam logic [SEL_W-1:0] OFS_RUN    = 3'd3;
    localparam logic [SEL_W-1:0] OFS_STATUS = 3'd4;

    typedef enum logic [1:0] {
        MODE_STREAM   = 2'd0,
        MODE_BUF_IRQ  = 2'd1,
        MODE_BUF_POLL = 2'd2,
        MODE_BUF_ALT  = 2'd3
    } chan_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULL,
        ST_REQ,
        ST_WAIT,
        ST_PUSH,
        ST_DONE,
        ST_FAULT
    } chan_state_e;

    typedef struct packed {
        logic fault;
        logic done;
    } chan_status_t;

    function automatic logic is_stream(chan_mode_e m);
        return m == MODE_STREAM;
    endfunction

    function automatic logic irq_on_done(chan_mode_e m);
        return m == MODE_BUF_IRQ;
    endfunction
endpackage

// File: rtl/cmc_regbank.sv
module cmc_regbank
    import cmc_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LEN_W  = DEF_LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  chan_status_t      status_i,
    output chan_mode_e        mode_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              run_o
);
    logic [1:0]        mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            base_q <= '0;
            len_q  <= '0;
            run_q  <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                OFS_MODE: mode_q <= cfg_wdata[1:0];
                OFS_BASE: base_q <= cfg_wdata[ADDR_W-1:0];
                OFS_LEN:  len_q  <= cfg_wdata[LEN_W-1:0];
                OFS_RUN:  run_q  <= cfg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            OFS_MODE:   cfg_rdata[1:0]        = mode_q;
            OFS_BASE:   cfg_rdata[ADDR_W-1:0] = base_q;
            OFS_LEN:    cfg_rdata[LEN_W-1:0]  = len_q;
            OFS_RUN:    cfg_rdata             = run_q;
            OFS_STATUS: cfg_rdata[1:0]        = status_i;
            default:    cfg_rdata             = '0;
        endcase
    end

    assign mode_o = chan_mode_e'(mode_q);
    assign base_o = base_q;
    assign len_o  = len_q;
    assign run_o  = |run_q;

    AST_MODE_FIELD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == OFS_MODE) |=> (mode_q == $past(cfg_wdata[1:0]))); // R2
endmodule

// File: rtl/cmc_addr_gen.sv
module cmc_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam int CW = LEN_W + 1;

    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    logic [CW-1:0]     idx_inc;

    assign idx_inc = {1'b0, idx_q} + CW'(1);
    assign last_o  = idx_inc >= {1'b0, len_q};
    assign addr_o  = base_q + ADDR_W'(idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else if (load) begin
            base_q <= base_i;
            len_q  <= len_i;
            idx_q  <= '0;
        end else if (step) begin
            idx_q <= last_o ? '0 : idx_inc[LEN_W-1:0];
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (len_q != '0) |-> (idx_q < len_q)); // R6
    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        (step && !load && last_o) |=> (addr_o == base_q)); // R6
endmodule

// File: rtl/cmc_engine.sv
module cmc_engine
    import cmc_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int LEN_W    = DEF_LEN_W,
    parameter bit TO_COPRO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  chan_mode_e        mode_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              ag_load,
    output logic              ag_step,
    input  logic [ADDR_W-1:0] ag_addr,
    input  logic              ag_last,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              cop_out_valid,
    input  logic              cop_out_ready,
    output logic [DATA_W-1:0] cop_out_data,
    input  logic              cop_in_valid,
    output logic              cop_in_ready,
    input  logic [DATA_W-1:0] cop_in_data,
    output chan_status_t      status_o,
    output logic              irq_o
);
    chan_state_e       st_q, st_d;
    chan_mode_e        mode_q;
    logic [DATA_W-1:0] data_q;
    logic              advance;
    logic              capture;

    always_comb begin
        st_d    = st_q;
        ag_load = 1'b0;
        advance = 1'b0;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (run_i) begin
                    ag_load = 1'b1;
                    if (!is_stream(mode_i) && len_i == '0) st_d = ST_DONE;
                    else if (TO_COPRO)                    st_d = ST_REQ;
                    else                                  st_d = ST_PULL;
                end
            end
            ST_PULL: begin
                if (cop_in_valid && cop_in_ready) begin
                    capture = 1'b1;
                    st_d    = ST_REQ;
                end else if (!run_i) begin
                    st_d = ST_IDLE;
                end
            end
            ST_REQ: if (mem_req_ready) st_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        st_d = ST_FAULT;
                    end else if (TO_COPRO) begin
                        capture = 1'b1;
                        st_d    = ST_PUSH;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            ST_PUSH:  if (cop_out_ready) advance = 1'b1;
            ST_DONE:  if (!run_i) st_d = ST_IDLE;
            ST_FAULT: if (!run_i) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
        if (advance) begin
            if (!is_stream(mode_q) && ag_last) st_d = ST_DONE;
            else if (!run_i)                   st_d = ST_IDLE;
            else if (TO_COPRO)                 st_d = ST_REQ;
            else                               st_d = ST_PULL;
        end
        ag_step = advance;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= MODE_STREAM;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (ag_load) mode_q <= mode_i;
            if (capture) data_q <= TO_COPRO ? mem_rsp_rdata : cop_in_data;
        end
    end

    assign mem_req_valid   = (st_q == ST_REQ);
    assign mem_req_write   = (TO_COPRO == 1'b0);
    assign mem_req_addr    = ag_addr;
    assign mem_req_wdata   = data_q;
    assign cop_out_valid   = TO_COPRO && (st_q == ST_PUSH);
    assign cop_out_data    = data_q;
    assign cop_in_ready    = !TO_COPRO && (st_q == ST_PULL) && run_i;
    assign status_o.done   = (st_q == ST_DONE);
    assign status_o.fault  = (st_q == ST_FAULT);
    assign irq_o           = status_o.fault || (status_o.done && irq_on_done(mode_q));

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cop_out_valid && !cop_out_ready) |=> (cop_out_valid && $stable(cop_out_data))); // R4
    AST_STREAM_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        status_o.done |-> !is_stream(mode_q)); // R6
    AST_DONE_PARKED: assert property (@(posedge clk) disable iff (rst)
        (status_o.done && run_i) |=> (status_o.done && !mem_req_valid)); // R7
    AST_FAULT_RAISE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && mem_rsp_valid && mem_rsp_err) |=> (irq_o && status_o.fault)); // R9
    AST_CLEAR_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        (!run_i && (status_o.done || status_o.fault)) |=> (!status_o.done && !status_o.fault && !irq_o)); // R10
endmodule

// File: rtl/copro_mem_channel.sv
module copro_mem_channel
    import cmc_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int LEN_W    = DEF_LEN_W,
    parameter bit TO_COPRO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              cop_out_valid,
    input  logic              cop_out_ready,
    output logic [DATA_W-1:0] cop_out_data,
    input  logic              cop_in_valid,
    output logic              cop_in_ready,
    input  logic [DATA_W-1:0] cop_in_data,
    output logic              irq
);
    chan_status_t      status;
    chan_mode_e        mode;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;
    logic              run;
    logic              ag_load, ag_step, ag_last;
    logic [ADDR_W-1:0] ag_addr;

    cmc_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .status_i(status),
        .mode_o(mode), .base_o(base), .len_o(len), .run_o(run)
    );

    cmc_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk(clk), .rst(rst), .load(ag_load), .step(ag_step),
        .base_i(base), .len_i(len), .addr_o(ag_addr), .last_o(ag_last)
    );

    cmc_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TO_COPRO(TO_COPRO)) u_eng (
        .clk(clk), .rst(rst), .run_i(run), .mode_i(mode), .len_i(len),
        .ag_load(ag_load), .ag_step(ag_step), .ag_addr(ag_addr), .ag_last(ag_last),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
        .cop_out_valid(cop_out_valid), .cop_out_ready(cop_out_ready),
        .cop_out_data(cop_out_data), .cop_in_valid(cop_in_valid),
        .cop_in_ready(cop_in_ready), .cop_in_data(cop_in_data),
        .status_o(status), .irq_o(irq)
    );
endmodule

// File: tb/sim_copro_mem_channel.sv
`timescale 1ns/1ps
module sim_copro_mem_channel;
    import cmc_pkg::*;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [2:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          a_we = 1'b0, b_we = 1'b0;
    logic [DW-1:0] a_rdata, b_rdata;

    logic a_req_valid, a_req_ready = 1'b1, a_req_write;
    logic [AW-1:0] a_req_addr;
    logic [DW-1:0] a_req_wdata;
    logic a_rsp_valid = 1'b0, a_rsp_err = 1'b0;
    logic [DW-1:0] a_rsp_rdata = '0;
    logic a_out_valid, a_out_ready = 1'b1;
    logic [DW-1:0] a_out_data;
    logic a_in_ready, a_irq;

    logic b_req_valid, b_req_ready = 1'b1, b_req_write;
    logic [AW-1:0] b_req_addr;
    logic [DW-1:0] b_req_wdata;
    logic b_rsp_valid = 1'b0, b_rsp_err = 1'b0;
    logic [DW-1:0] b_rsp_rdata = '0;
    logic b_out_valid;
    logic [DW-1:0] b_out_data;
    logic b_in_valid = 1'b0, b_in_ready;
    logic [DW-1:0] b_in_data = '0;
    logic b_irq;

    copro_mem_channel #(.TO_COPRO(1'b1)) u0 (
        .clk(clk), .rst(rst), .cfg_we(a_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(a_rdata), .mem_req_valid(a_req_valid), .mem_req_ready(a_req_ready),
        .mem_req_write(a_req_write), .mem_req_addr(a_req_addr), .mem_req_wdata(a_req_wdata),
        .mem_rsp_valid(a_rsp_valid), .mem_rsp_err(a_rsp_err), .mem_rsp_rdata(a_rsp_rdata),
        .cop_out_valid(a_out_valid), .cop_out_ready(a_out_ready), .cop_out_data(a_out_data),
        .cop_in_valid(1'b0), .cop_in_ready(a_in_ready), .cop_in_data('0), .irq(a_irq)
    );

    copro_mem_channel #(.TO_COPRO(1'b0)) u1 (
        .clk(clk), .rst(rst), .cfg_we(b_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(b_rdata), .mem_req_valid(b_req_valid), .mem_req_ready(b_req_ready),
        .mem_req_write(b_req_write), .mem_req_addr(b_req_addr), .mem_req_wdata(b_req_wdata),
        .mem_rsp_valid(b_rsp_valid), .mem_rsp_err(b_rsp_err), .mem_rsp_rdata(b_rsp_rdata),
        .cop_out_valid(b_out_valid), .cop_out_ready(1'b0), .cop_out_data(b_out_data),
        .cop_in_valid(b_in_valid), .cop_in_ready(b_in_ready), .cop_in_data(b_in_data), .irq(b_irq)
    );

    // reference model state
    logic [AW-1:0] a_base = '0, a_paddr = '0, a_err_addr = '0;
    int a_len = 0, a_idx = 0, a_nreq = 0, a_nout = 0;
    bit a_pend = 0, a_stall = 0, a_err_en = 0;
    logic [DW-1:0] a_outq[$];

    logic [AW-1:0] b_base = '0;
    int b_len = 0, b_idx = 0, b_nreq = 0;
    bit b_pend = 0, b_hs = 0;
    logic [DW-1:0] b_src[$];
    logic [DW-1:0] b_wq[$];

    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        return (a * 32'h0001_0003) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    // memory and coprocessor models, compared every clock
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                a_pend = 0; a_rsp_valid = 0; b_pend = 0; b_rsp_valid = 0; b_hs = 0;
            end else begin
                a_rsp_valid = a_pend;
                a_rsp_err   = 1'b0;
                if (a_pend) begin
                    a_rsp_rdata = memval(a_paddr);
                    a_rsp_err   = a_err_en && (a_paddr == a_err_addr);
                    if (!a_rsp_err) a_outq.push_back(a_rsp_rdata);
                    a_pend = 0;
                end
                a_req_ready = !(a_stall && (cyc % 2 == 1));
                a_out_ready = !(a_stall && (cyc % 3 == 0));
                if (a_rsp_valid) chk_eq("R5 no request while response due", a_req_valid, 1'b0);
                if (a_req_valid && a_req_ready) begin
                    chk_eq("R3/R6 read address", a_req_addr, a_base + a_idx);
                    chk_eq("R4 read direction", a_req_write, 1'b0);
                    a_idx = (a_idx + 1 >= a_len) ? 0 : a_idx + 1;
                    a_nreq++;
                    a_paddr = a_req_addr;
                    a_pend = 1;
                end
                if (a_out_valid && a_out_ready) begin
                    if (a_outq.size() == 0) chk(0, "R4 unexpected output word", a_out_data, 0);
                    else chk_eq("R4 output word", a_out_data, a_outq.pop_front());
                    a_nout++;
                end

                b_rsp_valid = b_pend;
                b_rsp_err   = 1'b0;
                b_rsp_rdata = '0;
                b_pend = 0;
                if (b_hs && b_src.size() > 0) b_wq.push_back(b_src.pop_front());
                b_in_valid = (b_src.size() > 0);
                b_in_data  = b_in_valid ? b_src[0] : '0;
                b_hs = b_in_valid && b_in_ready;
                b_req_ready = 1'b1;
                if (b_req_valid && b_req_ready) begin
                    chk_eq("R4 write address", b_req_addr, b_base + b_idx);
                    chk_eq("R4 write direction", b_req_write, 1'b1);
                    if (b_wq.size() == 0) chk(0, "R4 write without input word", b_req_wdata, 0);
                    else chk_eq("R4 write data", b_req_wdata, b_wq.pop_front());
                    b_idx = (b_idx + 1 >= b_len) ? 0 : b_idx + 1;
                    b_nreq++;
                    b_pend = 1;
                end
            end
        end
    end

    task automatic wr(input bit to_b, input logic [2:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_sel = s; cfg_wdata = d;
        if (to_b) b_we = 1'b1; else a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
    endtask

    task automatic rd(input bit to_b, input logic [2:0] s, output logic [DW-1:0] v);
        @(negedge clk);
        cfg_sel = s;
        #1;
        v = to_b ? b_rdata : a_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_a(input logic [1:0] m, input logic [AW-1:0] base, input int len, input logic [DW-1:0] runv);
        a_base = base; a_len = len; a_idx = 0; a_nreq = 0; a_nout = 0;
        a_outq.delete();
        wr(0, OFS_MODE, {30'd0, m});
        wr(0, OFS_BASE, base);
        wr(0, OFS_LEN, len);
        wr(0, OFS_RUN, runv);
    endtask

    task automatic wait_nout(input int n);
        for (int i = 0; i < 600 && a_nout < n; i++) @(negedge clk);
    endtask

    logic [DW-1:0] v;
    int snap;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk_eq("R1 irq after reset", a_irq, 1'b0);
        chk_eq("R1 no request after reset", a_req_valid, 1'b0);
        chk_eq("R1 no output after reset", a_out_valid, 1'b0);
        chk_eq("R1 no input accept after reset", b_in_ready, 1'b0);
        rd(0, OFS_STATUS, v); chk_eq("R1 status after reset", v, 0);

        // R2 register map
        wr(0, OFS_MODE, 32'hFFFF_FFFE); rd(0, OFS_MODE, v); chk_eq("R2 mode field width", v, 2);
        wr(0, OFS_BASE, 32'hDEAD_BEE0); rd(0, OFS_BASE, v); chk_eq("R2 base readback", v, 32'hDEAD_BEE0);
        wr(0, OFS_LEN, 32'h0001_0005);  rd(0, OFS_LEN, v);  chk_eq("R2 length width", v, 5);
        wr(0, OFS_STATUS, 32'h3);       rd(0, OFS_STATUS, v); chk_eq("R2 status write ignored", v, 0);
        chk_eq("R2 status write ignored irq", a_irq, 1'b0);
        rd(0, 3'd5, v); chk_eq("R2 unused offset", v, 0);
        rd(0, OFS_RUN, v); chk_eq("R2 run readback", v, 0);

        // R7 R8: single buffer with interrupt
        start_a(2'd1, 32'd100, 4, 32'h8000_0000);
        wait_nout(4); idle(3);
        rd(0, OFS_STATUS, v); chk_eq("R7 done after buffer", v, 1);
        chk_eq("R8 irq on completion (mode 1)", a_irq, 1'b1);
        chk_eq("R7 request count", a_nreq, 4);
        idle(10);
        chk_eq("R7 parked no requests", a_nreq, 4);
        rd(0, OFS_STATUS, v); chk_eq("R7 done held", v, 1);
        wr(0, OFS_RUN, 0); idle(3);
        rd(0, OFS_STATUS, v); chk_eq("R10 status cleared", v, 0);
        chk_eq("R10 irq cleared", a_irq, 1'b0);

        // R8 polled mode with back-pressure
        a_stall = 1;
        start_a(2'd2, 32'd300, 5, 32'h40);
        wait_nout(5); idle(4);
        rd(0, OFS_STATUS, v); chk_eq("R8 done visible (mode 2)", v, 1);
        chk_eq("R8 no irq (mode 2)", a_irq, 1'b0);
        chk_eq("R7 request count stalled", a_nreq, 5);
        wr(0, OFS_RUN, 0); idle(3);
        a_stall = 0;

        // R3 mode 3 acts as polled
        start_a(2'd3, 32'd350, 2, 32'h2);
        wait_nout(2); idle(3);
        rd(0, OFS_STATUS, v); chk_eq("R3 mode 3 done", v, 1);
        chk_eq("R3 mode 3 no irq", a_irq, 1'b0);
        wr(0, OFS_RUN, 0); idle(3);

        // R6 stream wrap
        start_a(2'd0, 32'd200, 3, 32'hFFFF_FFFF);
        wait_nout(8);
        rd(0, OFS_STATUS, v); chk_eq("R6 stream never done", v, 0);
        chk_eq("R6 stream irq low", a_irq, 1'b0);
        chk(a_nreq >= 8, "R6 stream wrapped", a_nreq, 8);
        wr(0, OFS_RUN, 0); idle(12);
        snap = a_nreq; idle(12);
        chk_eq("R10 stream stopped", a_nreq, snap);
        chk_eq("R10 stream words delivered", a_nout, a_nreq);

        // R9 error in polled buffer
        a_err_en = 1; a_err_addr = 32'd402;
        start_a(2'd2, 32'd400, 6, 32'h5);
        idle(20);
        chk_eq("R9 stop after error", a_nreq, 3);
        rd(0, OFS_STATUS, v); chk_eq("R9 error status", v, 2);
        chk_eq("R9 irq on error", a_irq, 1'b1);
        chk_eq("R9 good words out", a_nout, 2);
        wr(0, OFS_RUN, 0); idle(3);
        rd(0, OFS_STATUS, v); chk_eq("R10 error cleared", v, 0);
        chk_eq("R10 irq cleared after error", a_irq, 1'b0);

        // R9 error in stream
        a_err_addr = 32'd501;
        start_a(2'd0, 32'd500, 4, 32'h7);
        idle(20);
        rd(0, OFS_STATUS, v); chk_eq("R9 stream error status", v, 2);
        chk_eq("R9 stream irq", a_irq, 1'b1);
        chk_eq("R9 stream stopped", a_nreq, 2);
        wr(0, OFS_RUN, 0); idle(3);
        a_err_en = 0;

        // R11 zero length
        start_a(2'd1, 32'd600, 0, 32'h9);
        idle(6);
        chk_eq("R11 no access", a_nreq, 0);
        rd(0, OFS_STATUS, v); chk_eq("R11 done", v, 1);
        chk_eq("R11 irq mode 1", a_irq, 1'b1);
        wr(0, OFS_RUN, 0); idle(3);

        // R4 from-coprocessor writes
        b_base = 32'd700; b_len = 3; b_idx = 0; b_nreq = 0;
        b_src.push_back(32'hA1); b_src.push_back(32'hB2); b_src.push_back(32'hC3);
        wr(1, OFS_MODE, 2); wr(1, OFS_BASE, 32'd700); wr(1, OFS_LEN, 3); wr(1, OFS_RUN, 1);
        for (int i = 0; i < 200 && b_nreq < 3; i++) @(negedge clk);
        idle(5);
        chk_eq("R4 write count", b_nreq, 3);
        rd(1, OFS_STATUS, v); chk_eq("R8 write channel done", v, 1);
        chk_eq("R8 write channel no irq", b_irq, 1'b0);
        chk_eq("R4 all words written", b_wq.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule